// File: doc/BRIEF.md
# MDIO Management Bus Master

This block runs one management-register access at a time towards an Ethernet PHY over a two-wire serial link. The link is a clock line (MDC) and a bidirectional data line (MDIO). A host presents a PHY address, a register address, a read/write select and, for writes, a 16-bit value, and then pulses `start_i`. The block frames the access, shifts it out bit by bit and pulses `done_o` when it has finished. A read returns 16 bits of data, or an error flag if no PHY answered.

The data line leaves the block as three separate signals: a value, an output enable and a sampled input. The bidirectional pad is built outside the block. MDC is derived from the system clock. Each MDC half-period lasts `DIV` system clocks. MDC rests high between accesses, and every MDC cycle of an access starts with its low half.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever no access is in progress, MDC is high, the MDIO output enable is low and `busy_o` is low. After reset, `done_o`, `rdata_o` and `err_o` are all zero.
- R2: A start pulse seen while idle pulls MDC low on the same clock edge that accepts it. From then on, each MDC half-period lasts exactly `DIV` clocks, and each MDC cycle is a low half followed by a high half.
- R3: Every access begins with 32 cycles driving 1, then 0, then 1. Next comes the operation code: 1,0 for a read or 0,1 for a write. Then the 5-bit PHY address and the 5-bit register address follow, each most significant bit first. The output enable is high for all of these 46 cycles.
- R4: The MDIO value and the output enable change only on the clock edge where MDC falls. They then hold for the whole of that MDC cycle.
- R5: A write sends the turnaround bits 1,0 and then the 16 data bits, most significant first, all driven. One more MDC cycle follows with MDIO released. The write ends after 65 MDC cycles, with `err_o` at 0 and `rdata_o` at 0.
- R6: A read releases MDIO from the first turnaround cycle to the end of the access. The input is sampled on the last clock of each high half. The 16 bits sampled in the cycles after the turnaround form `rdata_o`, most significant first. Two further MDC cycles follow, so the read ends after 66 MDC cycles with `err_o` at 0.
- R7: If a read samples 1 during the second turnaround cycle, 32 recovery cycles follow with MDIO released. The read then ends after 80 MDC cycles in all, with `err_o` at 1 and `rdata_o` at 0.
- R8: `busy_o` is high from the accepting edge until the final high half ends. `done_o` is a one-clock pulse in the clock right after that, and `busy_o` is already low in that clock.
- R9: A start pulse that arrives while `busy_o` is high has no effect. The running access keeps its timing and content, and no second access follows it.
- R10: `rdata_o` and `err_o` change only in the clock where `done_o` is high, and then hold until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-clock request to begin an access |
| read_i | input | 1 | 1 selects a read, 0 a write; sampled with start |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register address |
| wdata_i | input | 16 | Value to write |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 16 | Data returned by the last read |
| err_o | output | 1 | Last read got no turnaround response |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Value to drive on the data line |
| mdio_oe_o | output | 1 | Drive enable for the data line |
| mdio_i | input | 1 | Data line as seen at the pad |

## Verification
The properties assume that the host keeps the request inputs steady only in the accepting clock, and that `mdio_i` may take any value at any time. For that reason no property relates `mdio_i` to what is captured. The bench drives `mdio_i` from a PHY model that changes the line once per MDC cycle, on the falling clock edge, and holds it across the sampling edge. Extra start pulses are injected in mid-access to exercise R9.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_HDR,
      PH_TA,
      PH_DATA,
      PH_TAIL
   } mdio_phase_e;

   localparam logic [1:0] SOF_BITS  = 2'b01;
   localparam logic [1:0] OP_READ   = 2'b10;
   localparam logic [1:0] OP_WRITE  = 2'b01;
   localparam logic [1:0] TA_DRIVEN = 2'b10;
endpackage

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic half_end_o
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

   if (DIV < 1) begin : g_bad_div
      $error("mdio_half_timer: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_every_clk
      assign half_end_o = run_i;
   end else begin : g_counter
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    cnt_q <= '0;
         else if (!run_i)               cnt_q <= '0;
         else if (cnt_q == CW'(DIV-1))  cnt_q <= '0;
         else                           cnt_q <= cnt_q + 1'b1;
      end
      assign half_end_o = run_i && (cnt_q == CW'(DIV-1));
   end
endmodule

// File: rtl/mdio_tx_shifter.sv
module mdio_tx_shifter #(
   parameter int W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         shift_i,
   output logic         bit_o
);
   logic [W-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sr_q <= '0;
      else if (load_i)   sr_q <= load_val_i;
      else if (shift_i)  sr_q <= {sr_q[W-2:0], 1'b0};
   end

   assign bit_o = sr_q[W-1];
endmodule

// File: rtl/mdio_rx_shifter.sv
module mdio_rx_shifter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_i,
   input  logic         bit_i,
   output logic [W-1:0] word_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_o <= '0;
      else if (shift_i) word_o <= {word_o[W-2:0], bit_i};
   end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_pkg::*;
#(
   parameter int DIV       = 4,
   parameter int ADDR_W    = 5,
   parameter int DATA_W    = 16,
   parameter int PRE_LEN   = 32,
   parameter int RECOV_LEN = 32,
   parameter int RD_TAIL   = 2,
   parameter int WR_TAIL   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              read_i,
   input  logic [ADDR_W-1:0] phy_addr_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              err_o,
   output logic              mdc_o,
   output logic              mdio_o,
   output logic              mdio_oe_o,
   input  logic              mdio_i
);
   localparam int HDR_LEN   = PRE_LEN + 4 + 2*ADDR_W;
   localparam int TX_W      = HDR_LEN + 2 + DATA_W;
   localparam int MAX_A     = (HDR_LEN > DATA_W) ? HDR_LEN : DATA_W;
   localparam int MAX_B     = (RECOV_LEN > RD_TAIL) ? RECOV_LEN : RD_TAIL;
   localparam int MAX_SLOTS = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int SLOT_W    = $clog2(MAX_SLOTS + 1);

   if (DIV < 1 || ADDR_W < 1 || DATA_W < 2 || PRE_LEN < 1) begin : g_bad_cfg
      $error("mdio_master: illegal width, length or divider parameter");
   end
   if (RECOV_LEN < 1 || RD_TAIL < 1 || WR_TAIL < 1) begin : g_bad_tail
      $error("mdio_master: tail lengths must be at least 1");
   end

   mdio_phase_e       phase_q, nxt_phase;
   logic [SLOT_W-1:0] slot_q, nxt_slot, tail_last;
   logic              is_rd_q, fail_q, nxt_fail;
   logic              oe_q, nxt_oe, mdc_q;
   logic              half_end, slot_end, last_slot, accept;
   logic [TX_W-1:0]   frame;
   logic [DATA_W-1:0] rx_word;

   assign accept   = start_i && !busy_o;
   assign slot_end = half_end && mdc_q;
   assign frame    = {{PRE_LEN{1'b1}}, SOF_BITS, (read_i ? OP_READ : OP_WRITE),
                      phy_addr_i, reg_addr_i, TA_DRIVEN, wdata_i};

   mdio_half_timer #(.DIV(DIV)) u_timer (
      .clk(clk), .rst_n(rst_n), .run_i(busy_o), .half_end_o(half_end)
   );

   mdio_tx_shifter #(.W(TX_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .load_i(accept), .load_val_i(frame),
      .shift_i(slot_end && !last_slot), .bit_o(mdio_o)
   );

   mdio_rx_shifter #(.W(DATA_W)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .shift_i(slot_end && is_rd_q && (phase_q == PH_DATA)),
      .bit_i(mdio_i), .word_o(rx_word)
   );

   always_comb begin
      if (fail_q)       tail_last = SLOT_W'(RECOV_LEN - 1);
      else if (is_rd_q) tail_last = SLOT_W'(RD_TAIL - 1);
      else              tail_last = SLOT_W'(WR_TAIL - 1);
   end

   always_comb begin
      nxt_phase = phase_q;
      nxt_slot  = slot_q + 1'b1;
      nxt_oe    = oe_q;
      nxt_fail  = fail_q;
      last_slot = 1'b0;
      case (phase_q)
         PH_HDR: if (slot_q == SLOT_W'(HDR_LEN - 1)) begin
            nxt_phase = PH_TA;
            nxt_slot  = '0;
            nxt_oe    = !is_rd_q;
         end
         PH_TA: if (slot_q == SLOT_W'(1)) begin
            nxt_slot = '0;
            if (is_rd_q && mdio_i) begin
               nxt_phase = PH_TAIL;
               nxt_fail  = 1'b1;
               nxt_oe    = 1'b0;
            end else begin
               nxt_phase = PH_DATA;
            end
         end
         PH_DATA: if (slot_q == SLOT_W'(DATA_W - 1)) begin
            nxt_phase = PH_TAIL;
            nxt_slot  = '0;
            nxt_oe    = 1'b0;
         end
         PH_TAIL: last_slot = (slot_q == tail_last);
         default: last_slot = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         slot_q  <= '0;
         is_rd_q <= 1'b0;
         fail_q  <= 1'b0;
         oe_q    <= 1'b0;
         mdc_q   <= 1'b1;
         busy_o  <= 1'b0;
         done_o  <= 1'b0;
         rdata_o <= '0;
         err_o   <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (accept) begin
            phase_q <= PH_HDR;
            slot_q  <= '0;
            is_rd_q <= read_i;
            fail_q  <= 1'b0;
            oe_q    <= 1'b1;
            mdc_q   <= 1'b0;
            busy_o  <= 1'b1;
         end else if (half_end && !mdc_q) begin
            mdc_q <= 1'b1;
         end else if (slot_end && last_slot) begin
            phase_q <= PH_IDLE;
            busy_o  <= 1'b0;
            done_o  <= 1'b1;
            oe_q    <= 1'b0;
            rdata_o <= (is_rd_q && !fail_q) ? rx_word : '0;
            err_o   <= fail_q;
         end else if (slot_end) begin
            phase_q <= nxt_phase;
            slot_q  <= nxt_slot;
            oe_q    <= nxt_oe;
            fail_q  <= nxt_fail;
            mdc_q   <= 1'b0;
         end
      end
   end

   assign mdc_o     = mdc_q;
   assign mdio_oe_o = oe_q;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
   parameter int DIV    = 4,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy_o,
   input logic              done_o,
   input logic [DATA_W-1:0] rdata_o,
   input logic              err_o,
   input logic              mdc_o,
   input logic              mdio_o,
   input logic              mdio_oe_o
);
   logic mdc_prev_q;
   int   run_len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mdc_prev_q <= 1'b1;
         run_len_q  <= 0;
      end else begin
         mdc_prev_q <= mdc_o;
         if (mdc_o != mdc_prev_q)  run_len_q <= 1;
         else if (run_len_q <= DIV) run_len_q <= run_len_q + 1;
      end
   end

   AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (mdc_o && !mdio_oe_o)); // R1

   AST_HALF_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      ((mdc_o != mdc_prev_q) && $past(busy_o)) |-> (run_len_q == DIV)); // R2

   AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($changed(mdio_o) || $changed(mdio_oe_o)) |-> $fell(mdc_o)); // R4

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R8

   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o))); // R8

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(rdata_o) && $stable(err_o))); // R10
endmodule

bind mdio_master mdio_master_chk #(.DIV(DIV), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o),
   .rdata_o(rdata_o), .err_o(err_o), .mdc_o(mdc_o), .mdio_o(mdio_o),
   .mdio_oe_o(mdio_oe_o)
);

// File: tb/mdio_master_tb_top.sv
`timescale 1ns/1ps
module mdio_master_tb_top;
   localparam int DIV = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0, read_i = 1'b0, mdio_i = 1'b1;
   logic [4:0]  phy_addr_i = '0, reg_addr_i = '0;
   logic [15:0] wdata_i = '0;
   logic        busy_o, done_o, err_o, mdc_o, mdio_o, mdio_oe_o;
   logic [15:0] rdata_o;

   int n_vec = 0, n_bad = 0;
   logic [15:0] last_rd = '0;
   logic        last_err = 1'b0;

   always #2.5 clk = ~clk;

   mdio_master #(.DIV(DIV)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .read_i(read_i),
      .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wdata_i(wdata_i),
      .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o), .err_o(err_o),
      .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
      end
   endtask

   task automatic run_txn(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                          input logic [15:0] wd, input bit ta_ok,
                          input logic [15:0] phy_dat, input bit poke);
      bit oe_q[$];
      bit val_q[$];
      bit in_q[$];
      int nslots, ncyc;
      logic [15:0] exp_rd;
      bit exp_err;
      bit prev_o;
      // header: preamble, 0 1, opcode, addresses (R3)
      for (int i = 0; i < 32; i++) begin oe_q.push_back(1); val_q.push_back(1); in_q.push_back(1); end
      oe_q.push_back(1); val_q.push_back(0); in_q.push_back(1);
      oe_q.push_back(1); val_q.push_back(1); in_q.push_back(1);
      oe_q.push_back(1); val_q.push_back(rd ? 1'b1 : 1'b0); in_q.push_back(1);
      oe_q.push_back(1); val_q.push_back(rd ? 1'b0 : 1'b1); in_q.push_back(1);
      for (int i = 4; i >= 0; i--) begin oe_q.push_back(1); val_q.push_back(pa[i]); in_q.push_back(1); end
      for (int i = 4; i >= 0; i--) begin oe_q.push_back(1); val_q.push_back(ra[i]); in_q.push_back(1); end
      if (!rd) begin
         oe_q.push_back(1); val_q.push_back(1); in_q.push_back(1);
         oe_q.push_back(1); val_q.push_back(0); in_q.push_back(1);
         for (int i = 15; i >= 0; i--) begin oe_q.push_back(1); val_q.push_back(wd[i]); in_q.push_back(1); end
         oe_q.push_back(0); val_q.push_back(0); in_q.push_back(1);
         exp_rd = '0; exp_err = 0;
      end else begin
         oe_q.push_back(0); val_q.push_back(0); in_q.push_back(1);
         oe_q.push_back(0); val_q.push_back(0); in_q.push_back(ta_ok ? 1'b0 : 1'b1);
         if (ta_ok) begin
            for (int i = 15; i >= 0; i--) begin oe_q.push_back(0); val_q.push_back(0); in_q.push_back(phy_dat[i]); end
            for (int i = 0; i < 2; i++) begin oe_q.push_back(0); val_q.push_back(0); in_q.push_back(1); end
            exp_rd = phy_dat; exp_err = 0;
         end else begin
            for (int i = 0; i < 32; i++) begin oe_q.push_back(0); val_q.push_back(0); in_q.push_back(i[0]); end
            exp_rd = '0; exp_err = 1;
         end
      end
      nslots = oe_q.size();
      ncyc   = nslots * 2 * DIV;

      @(negedge clk);
      read_i = rd; phy_addr_i = pa; reg_addr_i = ra; wdata_i = wd; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      prev_o = 0;
      for (int k = 0; k < ncyc; k++) begin
         int slot;
         string tag;
         if (k > 0) @(negedge clk);
         slot = k / (2*DIV);
         mdio_i = in_q[slot];
         start_i = (poke && (k == 7 || k == ncyc - 2));   // R9 stray requests
         if (poke) begin read_i = ~rd; phy_addr_i = ~pa; wdata_i = ~wd; end
         if (slot < 46) tag = "R3";
         else if (!rd) tag = "R5";
         else if (ta_ok) tag = "R6";
         else tag = "R7";
         chk("R2 mdc", {31'd0, mdc_o}, {31'd0, ((k % (2*DIV)) >= DIV)});
         chk("R8 busy", {31'd0, busy_o}, 32'd1);
         chk({tag, " oe"}, {31'd0, mdio_oe_o}, {31'd0, oe_q[slot]});
         if (oe_q[slot]) chk({tag, " bit"}, {31'd0, mdio_o}, {31'd0, val_q[slot]});
         if ((k % (2*DIV)) != 0 && mdio_oe_o)
            chk("R4 hold", {31'd0, mdio_o}, {31'd0, prev_o});
         prev_o = mdio_o;
         if (k == ncyc / 2) begin
            chk("R10 rdata held", {16'd0, rdata_o}, {16'd0, last_rd});
            chk("R10 err held", {31'd0, err_o}, {31'd0, last_err});
         end
      end
      @(negedge clk);
      start_i = 1'b0; mdio_i = 1'b1;
      chk("R8 done", {31'd0, done_o}, 32'd1);
      chk("R8 busy low", {31'd0, busy_o}, 32'd0);
      chk("R1 mdc idle", {31'd0, mdc_o}, 32'd1);
      chk("R1 oe idle", {31'd0, mdio_oe_o}, 32'd0);
      chk(rd ? (ta_ok ? "R6 rdata" : "R7 rdata") : "R5 rdata", {16'd0, rdata_o}, {16'd0, exp_rd});
      chk(rd ? (ta_ok ? "R6 err" : "R7 err") : "R5 err", {31'd0, err_o}, {31'd0, exp_err});
      last_rd = exp_rd; last_err = exp_err;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk("R8 done pulse", {31'd0, done_o}, 32'd0);
         chk("R9 stays idle", {31'd0, busy_o}, 32'd0);
         chk("R1 mdc high", {31'd0, mdc_o}, 32'd1);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      chk("R1 reset mdc", {31'd0, mdc_o}, 32'd1);
      chk("R1 reset oe", {31'd0, mdio_oe_o}, 32'd0);
      chk("R1 reset busy", {31'd0, busy_o}, 32'd0);
      chk("R1 reset done", {31'd0, done_o}, 32'd0);
      chk("R1 reset rdata", {16'd0, rdata_o}, 32'd0);
      chk("R1 reset err", {31'd0, err_o}, 32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 idle mdc", {31'd0, mdc_o}, 32'd1);

      run_txn(0, 5'h01, 5'h00, 16'hA53C, 1, 16'h0000, 0);
      run_txn(1, 5'h1F, 5'h15, 16'h0000, 1, 16'h8001, 0);
      run_txn(1, 5'h0A, 5'h11, 16'h0000, 0, 16'hFFFF, 0);
      run_txn(1, 5'h12, 5'h03, 16'h0000, 1, 16'h1234, 0);
      run_txn(0, 5'h00, 5'h00, 16'h0000, 1, 16'h0000, 1);
      run_txn(1, 5'h15, 5'h0A, 16'h0000, 1, 16'hFFFF, 1);
      run_txn(1, 5'h03, 5'h1C, 16'h0000, 0, 16'h0000, 1);
      run_txn(0, 5'h1E, 5'h07, 16'hFFFF, 1, 16'h0000, 0);

      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule